// File: doc/BRIEF.md
# Seven-to-one display-link serializer

This block turns a 21-bit parallel pixel word into three serial data lanes and one forwarded-clock lane. Each data lane sends seven bits per pixel period, so the lanes run at seven times the pixel rate. The fourth lane repeats a fixed seven-bit pattern that is framed to the data. A receiver can use that pattern to find word boundaries and to recover the pixel clock. The word holds 18 colour bits (six each of red, green and blue) and three timing bits: line sync, frame sync and data-ready. The package gives one packing convention for these fields, but the serializer treats the word as opaque bits.

All logic runs on the serial bit clock `ser_clk`. This clock is supplied at seven times the pixel clock and is assumed synchronous to it. The pixel clock `pix_clk` enters as a sampled input. A static input `cap_rise` picks which pixel-clock transition captures the parallel word. It defaults to falling-edge capture when tied low. A power-down input silences every lane and restarts the framing.

Top module: `disp_link_ser7`

## Requirements
- R1: At every `ser_clk` rising edge at which `rst_n` is sampled low, all four lane outputs go low after that edge.
- R2: Lane L (L = 0, 1, 2) carries word bits 7L through 7L+6. Within a frame, slot j (j = 0..6) of lane L carries word bit 7L+j, so the lowest-numbered bit goes first.
- R3: In every active frame the clock lane sends 1,1,0,0,0,1,1 in slots 0 to 6. Its slot 0 coincides with slot 0 of the data lanes.
- R4: With `cap_rise` high, the word is captured at the `ser_clk` edge where `pix_clk` is first sampled high after being sampled low. The `pix_data` value sampled at that edge is stored.
- R5: With `cap_rise` low, the word is captured at the edge where `pix_clk` is first sampled low after being sampled high. The `pix_data` value sampled at that edge is stored.
- R6: Number as edge 1 the first `ser_clk` rising edge at which both `rst_n` is high and `pwr_dn` is low. All lanes stay low after edges 1 to 6. Slot j of frame k (k >= 0) appears after edge 7+7k+j.
- R7: Each frame carries one complete captured word: the most recent capture made before the frame's first edge. A frame never mixes bits of two different words.
- R8: At every edge at which `pwr_dn` is sampled high, all four lanes go low after that edge, and they stay low while it remains high.
- R9: After `pwr_dn` falls, the output resumes with the R6 timing: six silent slots, then full frames only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Serial bit clock, seven times the pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled on ser_clk |
| cap_rise | input | 1 | 1 = capture on rising pixel edge, 0 = on falling edge |
| pwr_dn | input | 1 | Power-down; holds all lanes low |
| pix_data | input | 21 | Parallel pixel word |
| data_lane_o | output | 3 | Serial data lanes, bit L is lane L |
| clk_lane_o | output | 1 | Forwarded clock lane |

## Verification
Counting from the release edge, every lane output is a flop, so a slot value is visible one `ser_clk` edge after it is scheduled. Reset and power-down therefore silence the lanes after the same edge that samples them. The first frame bit follows the seventh edge after release. The bench drives inputs on falling `ser_clk` edges and samples on falling edges, and it keeps its own slot counter from the R6 numbering to locate frame starts. A capture needs at least one frame before it reaches the lanes. For that reason each data check waits several pixel periods after a stimulus change. The no-split check accepts only the old or the new word in every frame collected while the input changes.

// File: rtl/ser7_pkg.sv
// Shared constants and the pixel field convention for the 7:1 serializer.
package ser7_pkg;
    localparam int SLOT_COUNT  = 7;
    localparam int DATA_LANES  = 3;
    localparam int WORD_BITS   = SLOT_COUNT * DATA_LANES;
    // Forwarded clock pattern, bit 0 sent first: 1,1,0,0,0,1,1
    localparam logic [SLOT_COUNT-1:0] CLK_LANE_PATTERN = 7'b1100011;

    // One packing convention for the 21-bit word (bit 0 = red[0]).
    typedef struct packed {
        logic       data_ready;
        logic       frame_sync;
        logic       line_sync;
        logic [5:0] blue;
        logic [5:0] green;
        logic [5:0] red;
    } pixel_word_t;
endpackage

// File: rtl/ser7_capture.sv
// Samples the pixel clock on the serial clock and latches the parallel
// word on the selected pixel-clock transition.
// Assumes pix_clk is derived from ser_clk and changes away from its
// rising edge, so a single sampling flop suffices.
module ser7_capture #(
    parameter int WIDTH = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             pix_clk,
    input  logic             cap_rise,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] hold
);
    logic pix_q;
    logic rise_evt;
    logic fall_evt;
    logic take;

    // Previous sampled level of the pixel clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_q <= 1'b0;
        else        pix_q <= pix_clk;
    end

    // Transition detect and strobe selection.
    always_comb begin
        rise_evt = pix_clk & ~pix_q;
        fall_evt = ~pix_clk & pix_q;
        take     = cap_rise ? rise_evt : fall_evt;
    end

    // Holding register for the most recently captured word.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) hold <= '0;
        else if (take)        hold <= din;
    end

    AST_RISE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_rise && !pwr_dn && pix_clk && !$past(pix_clk)) |=> (hold == $past(din))); // R4
    AST_FALL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_rise && !pwr_dn && !pix_clk && $past(pix_clk)) |=> (hold == $past(din))); // R5
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn && $stable(pix_clk)) |=> $stable(hold)); // R7
endmodule

// File: rtl/ser7_frame_ctr.sv
// Slot counter that defines the seven-bit frame and pulses the word load
// on the last slot so the next frame starts with a fresh word.
module ser7_frame_ctr #(
    parameter int SLOTS = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pwr_dn,
    output logic [$clog2(SLOTS)-1:0]   slot,
    output logic                       load
);
    localparam int CW = $clog2(SLOTS);
    localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

    // Free-running modulo-SLOTS counter, restarted by reset or power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) slot <= '0;
        else if (slot == LAST) slot <= '0;
        else                   slot <= slot + 1'b1;
    end

    // Load strobe on the final slot of a frame.
    always_comb load = (slot == LAST);

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !pwr_dn) |=> (slot == '0)); // R6
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot <= LAST)); // R6
endmodule

// File: rtl/ser7_lane.sv
// One serial lane: parallel load at frame start, then LSB-first shift.
// The output is the low bit of the shift register, so it is registered.
module ser7_lane #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             load,
    input  logic [WIDTH-1:0] word,
    output logic             ser_o
);
    logic [WIDTH-1:0] sr;

    // Load, shift, or clear the lane shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) sr <= '0;
        else if (load)        sr <= word;
        else                  sr <= {1'b0, sr[WIDTH-1:1]};
    end

    // Serial output taken from the low end.
    always_comb ser_o = sr[0];

    AST_LANE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !pwr_dn) |=> (ser_o == $past(word[0]))); // R2
    AST_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !ser_o); // R8
endmodule

// File: rtl/disp_link_ser7.sv
// Display-link 7:1 serializer top. Captures the pixel word on the chosen
// pixel-clock edge, then emits it over DATA_LANES lanes plus a framed
// forwarded-clock lane. Everything runs on ser_clk (7x pixel clock).
module disp_link_ser7
    import ser7_pkg::*;
#(
    parameter int LANE_BITS = SLOT_COUNT,
    parameter int N_LANES   = DATA_LANES,
    parameter logic [LANE_BITS-1:0] CLK_PATTERN = CLK_LANE_PATTERN
) (
    input  logic                           ser_clk,
    input  logic                           rst_n,
    input  logic                           pix_clk,
    input  logic                           cap_rise,
    input  logic                           pwr_dn,
    input  logic [LANE_BITS*N_LANES-1:0]   pix_data,
    output logic [N_LANES-1:0]             data_lane_o,
    output logic                           clk_lane_o
);
    localparam int W  = LANE_BITS * N_LANES;
    localparam int CW = $clog2(LANE_BITS);

    logic [W-1:0]  held;
    logic [CW-1:0] slot;
    logic          load;

    ser7_capture #(.WIDTH(W)) u_cap (
        .clk(ser_clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
        .pix_clk(pix_clk), .cap_rise(cap_rise), .din(pix_data), .hold(held)
    );

    ser7_frame_ctr #(.SLOTS(LANE_BITS)) u_frm (
        .clk(ser_clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .slot(slot), .load(load)
    );

    // One shifter per data lane, each fed its seven-bit slice.
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        ser7_lane #(.WIDTH(LANE_BITS)) u_lane (
            .clk(ser_clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .load(load),
            .word(held[g*LANE_BITS +: LANE_BITS]), .ser_o(data_lane_o[g])
        );
    end

    // Clock lane: the same shifter reloaded with the constant pattern.
    ser7_lane #(.WIDTH(LANE_BITS)) u_clk_lane (
        .clk(ser_clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .load(load),
        .word(CLK_PATTERN), .ser_o(clk_lane_o)
    );

    AST_RESET_QUIET: assert property (@(posedge ser_clk)
        !rst_n |=> (data_lane_o == '0 && !clk_lane_o)); // R1
    AST_PDN_QUIET: assert property (@(posedge ser_clk) disable iff (!rst_n)
        pwr_dn |=> (data_lane_o == '0 && !clk_lane_o)); // R8
    AST_CLK_HEAD: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (load && !pwr_dn) |=> (clk_lane_o && slot == '0)); // R3
endmodule

// File: tb/disp_link_ser7_test.sv
module disp_link_ser7_test;
    localparam int CLK_P = 10;

    logic        ser_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        pix_clk = 1'b0;
    logic        cap_rise = 1'b1;
    logic        pwr_dn  = 1'b0;
    logic [20:0] pix_data = '0;
    logic [2:0]  data_lane_o;
    logic        clk_lane_o;

    logic [20:0] cur_a = '0;   // presented around the rising pixel edge
    logic [20:0] cur_b = '0;   // presented around the falling pixel edge
    int phase = 0;
    int nvec  = 0;
    int nfail = 0;

    disp_link_ser7 uut (
        .ser_clk(ser_clk), .rst_n(rst_n), .pix_clk(pix_clk), .cap_rise(cap_rise),
        .pwr_dn(pwr_dn), .pix_data(pix_data), .data_lane_o(data_lane_o),
        .clk_lane_o(clk_lane_o)
    );

    always #(CLK_P/2) ser_clk = ~ser_clk;

    // Pixel clock: 4 serial cycles high, 3 low; word A while high, B while low.
    initial begin
        forever begin
            @(negedge ser_clk); pix_clk = 1'b1; pix_data = cur_a;
            repeat (3) @(negedge ser_clk);
            @(negedge ser_clk); pix_clk = 1'b0; pix_data = cur_b;
            repeat (2) @(negedge ser_clk);
        end
    end

    // Expected slot position from the R6 numbering.
    always @(posedge ser_clk) begin
        if (!rst_n || pwr_dn) phase <= 0;
        else                  phase <= (phase == 6) ? 0 : phase + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic get_frame(output logic [20:0] w, output logic [6:0] p);
        do @(negedge ser_clk); while (phase != 0);
        for (int j = 0; j < 7; j++) begin
            if (j > 0) @(negedge ser_clk);
            for (int l = 0; l < 3; l++) w[7*l + j] = data_lane_o[l];
            p[j] = clk_lane_o;
        end
    endtask

    // Six silent slots after release, then clock-lane slot 0 high (R6/R9).
    task automatic check_restart(input string req);
        logic quiet = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge ser_clk);
            if (data_lane_o != 3'b000 || clk_lane_o) quiet = 1'b0;
        end
        chk({req, " silent slots"}, {31'd0, quiet}, 32'd1);
        @(negedge ser_clk);
        chk({req, " first slot clock"}, {31'd0, clk_lane_o}, 32'd1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (5) @(negedge ser_clk);
        chk("R1 lanes in reset", {28'd0, data_lane_o, clk_lane_o}, 32'd0);
        rst_n = 1'b1;
        check_restart("R6");
    endtask

    task automatic t_capture(input logic rise, input logic [20:0] a, input logic [20:0] b,
                             input string req);
        logic [20:0] w;
        logic [6:0]  p;
        cap_rise = rise; cur_a = a; cur_b = b;
        repeat (21) @(negedge ser_clk);
        get_frame(w, p);
        chk({req, " word"}, {11'd0, w}, {11'd0, rise ? a : b});
        chk("R3 clock pattern", {25'd0, p}, {25'd0, 7'b1100011});
    endtask

    task automatic t_no_split;
        logic [20:0] w;
        logic [6:0]  p;
        logic ok = 1'b1;
        cap_rise = 1'b1; cur_a = 21'h0AAAAA; cur_b = 21'h0;
        repeat (21) @(negedge ser_clk);
        fork
            begin repeat (10) @(negedge ser_clk); cur_a = 21'h155555; end
            begin
                for (int f = 0; f < 4; f++) begin
                    get_frame(w, p);
                    if (w != 21'h0AAAAA && w != 21'h155555) ok = 1'b0;
                end
            end
        join
        chk("R7 whole words", {31'd0, ok}, 32'd1);
        chk("R7 last frame new word", {11'd0, w}, {11'd0, 21'h155555});
    endtask

    task automatic t_power_down;
        logic quiet = 1'b1;
        logic [20:0] w;
        logic [6:0]  p;
        cur_a = 21'h1ABCDE;
        repeat (14) @(negedge ser_clk);
        pwr_dn = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge ser_clk);
            if (data_lane_o != 3'b000 || clk_lane_o) quiet = 1'b0;
        end
        chk("R8 quiet in power-down", {31'd0, quiet}, 32'd1);
        pwr_dn = 1'b0;
        check_restart("R9");
        get_frame(w, p);
        get_frame(w, p);
        chk("R9 data after resume", {11'd0, w}, {11'd0, 21'h1ABCDE});
        chk("R9 clock after resume", {25'd0, p}, {25'd0, 7'b1100011});
    endtask

    initial begin
        #(CLK_P * 150000);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge ser_clk);
        t_reset();
        t_capture(1'b1, 21'h00007F, 21'h0, "R2 lane0 slice");
        t_capture(1'b1, 21'h003F80, 21'h0, "R2 lane1 slice");
        t_capture(1'b1, 21'h1C0001, 21'h0, "R2 lane2 slice");
        t_capture(1'b1, 21'h12D687, 21'h0ED978, "R4 rising capture");
        t_capture(1'b0, 21'h12D687, 21'h0ED978, "R5 falling capture");
        t_capture(1'b0, 21'h000000, 21'h1FFFFF, "R5 falling all ones");
        t_no_split();
        t_power_down();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule